// File: doc/BRIEF.md
# Serial Control Register Interface

This block takes 8-bit command words arriving on a three-wire serial link (a shift clock, a data line and a latch strobe) and stores each word in one of four control registers. All three link inputs, and the two step-clock inputs, are brought into the block clock domain through synchronizers and edge detectors. Shifting happens on rising edges of the shift clock. A rising edge of the strobe commits the collected word, and the two most significant bits of the word pick the destination register.

Two commit times exist. Reference-level selects, output enables, holds, position resets, decay selects and the auxiliary channel settings follow the strobe directly. The direction and excitation-mode fields of the two stepping channels are parked in a per-channel pending slot. Each channel copies its pending slot to its outputs on the next rising edge of its own step clock. A newer word for the same channel overwrites a pending slot that has not yet been applied.

Top module: `scr_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every output is zero.
- R2: Data is sampled on each rising edge of the shift clock. The first bit shifted becomes D0. At the strobe, the word is the last 8 bits shifted.
- R3: A rising strobe edge commits the word to the register given by D7:D6. The codes are 00 = reference register, 01 = channel A, 10 = channel B, 11 = auxiliary register.
- R4: In the reference register, D1:D0 is channel A's reference select and D3:D2 is channel B's. D5:D4 is the auxiliary reference select. On ref_sel_o these fields sit at bits [1:0], [3:2] and [5:4]. Codes 0 to 3 select levels in descending order (0.2, 0.134, 0.1, 0.066).
- R5: In a channel register, D0 is output enable, D1 is hold and D2 is position reset. All three reach their outputs at the strobe, without waiting for a step edge.
- R6: In a channel register, D3 is direction and D5:D4 is excitation mode (00 two-phase, 01 one-two full torque, 10 one-two, 11 quarter-step). These fields keep their old output value until the next rising edge of that channel's step clock. They change at that edge.
- R7: A second word for the same channel, arriving before that channel's step edge, replaces the pending direction and mode. The step edge then applies only the newer values.
- R8: Shift-clock edges that occur while the strobe is high change neither the shifted word nor any register.
- R9: In the auxiliary register, D0 is channel A decay, D1 is channel B decay, D2 is auxiliary enable and D3 is auxiliary direction. All four follow the strobe directly.
- R10: A step edge changes nothing when its channel has no pending update. A step edge on one channel never applies the other channel's pending update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data, D0 first |
| ser_stb_i | input | 1 | Latch strobe, commits on rising edge |
| step_clk_i | input | 2 | Step clocks, bit 0 channel A, bit 1 channel B |
| ref_sel_o | output | 6 | Reference selects: A [1:0], B [3:2], aux [5:4] |
| out_en_o | output | 2 | Output enable per channel |
| hold_o | output | 2 | Step hold per channel |
| pos_rst_o | output | 2 | Position reset per channel |
| dir_o | output | 2 | Applied direction per channel |
| exc_mode_o | output | 4 | Applied excitation mode, A [1:0], B [3:2] |
| decay_o | output | 2 | Decay select per channel |
| aux_en_o | output | 1 | Auxiliary channel enable |
| aux_dir_o | output | 1 | Auxiliary channel direction |

## Verification
The assertions assume that every serial and step input is much slower than clk. Each level is assumed to last several block cycles, so the synchronizers see every edge and the data bit is stable when the shift-clock rise arrives. The assertions also assume that a strobe rise and a step rise for the same channel never fall in the same cycle. The stimulus holds each level for at least four block cycles, changes data only while the shift clock is low, and separates strobe pulses from step pulses by several cycles.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int WORD_W  = 8;
  localparam int NCH     = 2;
  localparam int REF_W   = 2;
  localparam int REF_N   = 3;
  localparam int MODE_W  = 2;
  localparam int SEL_LSB = WORD_W - 2;

  typedef enum logic [1:0] {
    DST_REF = 2'b00,
    DST_CHA = 2'b01,
    DST_CHB = 2'b10,
    DST_AUX = 2'b11
  } dst_e;

  // Lower six bits of a channel word, D5 down to D0.
  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              dir;
    logic              prst;
    logic              hold;
    logic              en;
  } ch_word_t;

  // Lower bits of the auxiliary word, D3 down to D0.
  typedef struct packed {
    logic       aux_dir;
    logic       aux_en;
    logic [1:0] decay;
  } aux_word_t;

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d[0] = d;
    end else begin : g_many
      always_comb begin
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/scr_shift.sv
module scr_shift
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              stb_s,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);

  logic              sclk_dq, stb_dq;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              sclk_rise, stb_rise, shift_en;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_dq;
    stb_rise  = stb_s & ~stb_dq;
    shift_en  = sclk_rise & ~stb_s;
  end

  // Next-state logic: LSB-first shift, word capture on strobe rise.
  always_comb begin
    shreg_d = shreg_q;
    if (shift_en) shreg_d = {sdat_s, shreg_q[WORD_W-1:1]};
    word_d  = word_q;
    vld_d   = 1'b0;
    if (stb_rise) begin
      word_d = shreg_q;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_dq <= 1'b0;
      stb_dq  <= 1'b0;
      shreg_q <= '0;
      word_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      sclk_dq <= sclk_s;
      stb_dq  <= stb_s;
      shreg_q <= shreg_d;
      word_q  <= word_d;
      vld_q   <= vld_d;
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;

  // R8
  shreg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> $stable(shreg_q));

  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

endmodule

// File: rtl/scr_regbank.sv
module scr_regbank
  import scr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    word_vld,
  input  logic [WORD_W-1:0]       word,
  input  logic [NCH-1:0]          step_s,
  output logic [REF_N*REF_W-1:0]  ref_sel_o,
  output logic [NCH-1:0]          out_en_o,
  output logic [NCH-1:0]          hold_o,
  output logic [NCH-1:0]          pos_rst_o,
  output logic [NCH-1:0]          dir_o,
  output logic [NCH*MODE_W-1:0]   exc_mode_o,
  output logic [NCH-1:0]          decay_o,
  output logic                    aux_en_o,
  output logic                    aux_dir_o
);

  dst_e      dst;
  ch_word_t  cw;
  aux_word_t aw;
  logic      wr_ref, wr_aux;
  logic [NCH-1:0] wr_ch;
  logic [NCH-1:0] step_dq, step_rise;

  always_comb begin
    dst    = dst_e'(word[WORD_W-1:SEL_LSB]);
    cw     = ch_word_t'(word[$bits(ch_word_t)-1:0]);
    aw     = aux_word_t'(word[$bits(aux_word_t)-1:0]);
    wr_ref = word_vld & (dst == DST_REF);
    wr_aux = word_vld & (dst == DST_AUX);
    wr_ch[0] = word_vld & (dst == DST_CHA);
    wr_ch[1] = word_vld & (dst == DST_CHB);
    step_rise = step_s & ~step_dq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_dq <= '0;
    else        step_dq <= step_s;
  end

  // Reference and auxiliary registers: commit at the strobe.
  logic [REF_N*REF_W-1:0] ref_q, ref_d;
  aux_word_t              aux_q, aux_d;

  always_comb begin
    ref_d = ref_q;
    if (wr_ref) ref_d = word[REF_N*REF_W-1:0];
    aux_d = aux_q;
    if (wr_aux) aux_d = aw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      aux_q <= '0;
    end else begin
      ref_q <= ref_d;
      aux_q <= aux_d;
    end
  end

  assign ref_sel_o = ref_q;
  assign decay_o   = aux_q.decay;
  assign aux_en_o  = aux_q.aux_en;
  assign aux_dir_o = aux_q.aux_dir;

  // R4
  ref_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> $stable(ref_sel_o));

  // Stepping channels: immediate fields plus a pending slot.
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic              en_q, en_d, hold_q, hold_d, prst_q, prst_d;
      logic              pv_q, pv_d, pdir_q, pdir_d, dir_q, dir_d;
      logic [MODE_W-1:0] pmode_q, pmode_d, mode_q, mode_d;

      always_comb begin
        en_d    = en_q;
        hold_d  = hold_q;
        prst_d  = prst_q;
        pv_d    = pv_q;
        pdir_d  = pdir_q;
        pmode_d = pmode_q;
        dir_d   = dir_q;
        mode_d  = mode_q;
        // Step edge applies whatever was pending before this cycle.
        if (step_rise[i] && pv_q) begin
          dir_d  = pdir_q;
          mode_d = pmode_q;
          pv_d   = 1'b0;
        end
        if (wr_ch[i]) begin
          en_d    = cw.en;
          hold_d  = cw.hold;
          prst_d  = cw.prst;
          pv_d    = 1'b1;
          pdir_d  = cw.dir;
          pmode_d = cw.mode;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q    <= 1'b0;
          hold_q  <= 1'b0;
          prst_q  <= 1'b0;
          pv_q    <= 1'b0;
          pdir_q  <= 1'b0;
          pmode_q <= '0;
          dir_q   <= 1'b0;
          mode_q  <= '0;
        end else begin
          en_q    <= en_d;
          hold_q  <= hold_d;
          prst_q  <= prst_d;
          pv_q    <= pv_d;
          pdir_q  <= pdir_d;
          pmode_q <= pmode_d;
          dir_q   <= dir_d;
          mode_q  <= mode_d;
        end
      end

      assign out_en_o[i]                     = en_q;
      assign hold_o[i]                       = hold_q;
      assign pos_rst_o[i]                    = prst_q;
      assign dir_o[i]                        = dir_q;
      assign exc_mode_o[i*MODE_W +: MODE_W]  = mode_q;

      // R6
      dir_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_rise[i] |=> ($stable(dir_o[i]) && $stable(exc_mode_o[i*MODE_W +: MODE_W])));

      // R10
      pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise[i] && !wr_ch[i]) |=> !pv_q);

      // R5
      imm_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> ($stable(out_en_o[i]) && $stable(hold_o[i])));
    end
  endgenerate

endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       ser_stb_i,
  input  logic [1:0] step_clk_i,
  output logic [5:0] ref_sel_o,
  output logic [1:0] out_en_o,
  output logic [1:0] hold_o,
  output logic [1:0] pos_rst_o,
  output logic [1:0] dir_o,
  output logic [3:0] exc_mode_o,
  output logic [1:0] decay_o,
  output logic       aux_en_o,
  output logic       aux_dir_o
);

  localparam int IN_W = 3 + NCH;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [IN_W-1:0] raw_in, sync_in;
  assign raw_in = {step_clk_i, ser_stb_i, ser_dat_i, ser_clk_i};

  scr_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (raw_in),
    .q     (sync_in)
  );

  logic              word_vld;
  logic [WORD_W-1:0] word;

  scr_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sclk_s     (sync_in[0]),
    .sdat_s     (sync_in[1]),
    .stb_s      (sync_in[2]),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  scr_regbank u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .word_vld   (word_vld),
    .word       (word),
    .step_s     (sync_in[IN_W-1:3]),
    .ref_sel_o  (ref_sel_o),
    .out_en_o   (out_en_o),
    .hold_o     (hold_o),
    .pos_rst_o  (pos_rst_o),
    .dir_o      (dir_o),
    .exc_mode_o (exc_mode_o),
    .decay_o    (decay_o),
    .aux_en_o   (aux_en_o),
    .aux_dir_o  (aux_dir_o)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n_s |-> (ref_sel_o == '0 && dir_o == '0 && out_en_o == '0 && exc_mode_o == '0));

endmodule

// File: tb/scr_ctrl_test.sv
module scr_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk, ser_dat, ser_stb;
  logic [1:0] step_clk;
  logic [5:0] ref_sel;
  logic [1:0] out_en, hold, pos_rst, dir, decay;
  logic [3:0] exc_mode;
  logic       aux_en, aux_dir;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  scr_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk_i  (ser_clk),
    .ser_dat_i  (ser_dat),
    .ser_stb_i  (ser_stb),
    .step_clk_i (step_clk),
    .ref_sel_o  (ref_sel),
    .out_en_o   (out_en),
    .hold_o     (hold),
    .pos_rst_o  (pos_rst),
    .dir_o      (dir),
    .exc_mode_o (exc_mode),
    .decay_o    (decay),
    .aux_en_o   (aux_en),
    .aux_dir_o  (aux_dir)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      ser_dat = b[k];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
    end
  endtask

  task automatic strobe();
    ser_stb = 1'b1;
    wait_clk(8);
    ser_stb = 1'b0;
    wait_clk(8);
  endtask

  task automatic send(input logic [7:0] b);
    shift_bits(b);
    strobe();
  endtask

  task automatic step(input int ch);
    step_clk[ch] = 1'b1;
    wait_clk(8);
    step_clk[ch] = 1'b0;
    wait_clk(8);
  endtask

  task automatic t_reset();
    check("R1 ref", ref_sel, 0);
    check("R1 en", out_en, 0);
    check("R1 dir", dir, 0);
    check("R1 mode", exc_mode, 0);
    check("R1 aux", {decay, aux_en, aux_dir, hold, pos_rst}, 0);
  endtask

  task automatic t_refsel();
    // 00 11 10 01: A=01, B=10, aux=11
    send(8'b0011_1001);
    check("R2 R4 ref", ref_sel, 6'b111001);
    check("R3 chan untouched", {out_en, dir}, 0);
  endtask

  task automatic t_imm_pend();
    // ch A: mode 10, dir 1, prst 1, hold 1, en 1
    send(8'b0110_1111);
    check("R5 en", out_en, 2'b01);
    check("R5 hold", hold, 2'b01);
    check("R5 prst", pos_rst, 2'b01);
    check("R6 dir waits", dir, 2'b00);
    check("R6 mode waits", exc_mode, 4'b0000);
    step(1);
    check("R10 other channel step", {dir, exc_mode}, 6'b00_0000);
    step(0);
    check("R6 dir applied", dir, 2'b01);
    check("R6 mode applied", exc_mode, 4'b0010);
  endtask

  task automatic t_replace();
    send(8'b0111_0001);
    send(8'b0101_1001);
    check("R5 hold cleared", hold, 2'b00);
    check("R7 still old mode", exc_mode, 4'b0010);
    step(0);
    check("R7 newer mode", exc_mode, 4'b0001);
    check("R7 newer dir", dir, 2'b01);
    step(0);
    check("R10 no pending", {dir, exc_mode}, 6'b01_0001);
  endtask

  task automatic t_chan_b();
    // ch B: mode 00, dir 1, prst 0, hold 1, en 0
    send(8'b1000_1010);
    check("R3 R5 hold B", hold, 2'b10);
    step(1);
    check("R6 dir B", dir, 2'b11);
    check("R6 mode kept A", exc_mode, 4'b0001);
  endtask

  task automatic t_stb_high();
    // aux: dir 0, en 1, decay B 0, decay A 1
    shift_bits(8'b1100_0101);
    ser_stb = 1'b1;
    wait_clk(8);
    shift_bits(8'b1100_1010);
    ser_stb = 1'b0;
    wait_clk(8);
    check("R9 decay", decay, 2'b01);
    check("R9 aux en", aux_en, 1'b1);
    strobe();
    check("R8 word kept", {decay, aux_en, aux_dir}, 4'b0110);
    check("R8 ref kept", ref_sel, 6'b111001);
  endtask

  initial begin
    rst_n = 1'b0;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_stb = 1'b0; step_clk = 2'b00;
    wait_clk(5);
    check("R1 in reset", {ref_sel, out_en, dir}, 0);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_refsel();
    t_imm_pend();
    t_replace();
    t_chan_b();
    t_stb_high();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule